// File: doc/BRIEF.md
# Tone Class Status Port

This block sits between a tone classifier and a host microcontroller. It takes the classifier's 4-bit tone-class code and masks it with a signal-level flag. The masked code is registered and shown on a parallel data word. The word is driven only while the host holds the active-low chip select, so the bus can be shared. Three-state behaviour is modelled as a separate drive-enable output. The pad logic outside this block turns that enable into high impedance.

Every change of the masked code raises an active-low, open-drain interrupt request, shown here as a pull-down enable. A host that keeps chip select high gets an interrupt that stays pending until chip select is next seen low. A host that ties chip select low permanently gets a self-timed pulse instead. The pulse lasts five periods of an external one-microsecond tick, and a further change while it runs restarts it. Pulling the enable pin low clears the block and releases the bus and the interrupt.

The interrupt controller is a three-state machine:
- `IRQ_IDLE`: the line is released.
- `IRQ_HOLD`: the interrupt is pending and waits for chip select low.
- `IRQ_PULSE`: the self-timed pulse is running.

The transitions are:
- `change_deselected`: a change while chip select is high leads to `IRQ_HOLD`, from any state.
- `change_selected`: a change while chip select is low leads to `IRQ_PULSE`, from any state. This restarts the pulse timer.
- `host_ack`: `IRQ_HOLD` goes to `IRQ_IDLE` when chip select is low and there is no change.
- `pulse_expire`: `IRQ_PULSE` goes to `IRQ_IDLE` on the fifth counted tick.
- `powersave`: any state goes to `IRQ_IDLE` while `enable` is low.

Top module: `tone_status_port`

## Requirements
- R1: `data_oe` is 1 exactly when `enable` is 1 and `csn` is 0, with no clock delay. Bit b of `data_out` equals bit b of the held code while `data_oe` is 1 and is 0 otherwise.
- R2: The effective code is `class_code` when `level_ok` is 1, and 0000 (no signal) when `level_ok` is 0. The held code takes the effective code at every clock edge while enabled and appears on the bus in the following cycle.
- R3: The effective code may differ from the held code at a clock edge while enabled. This includes changes into or out of 0000 caused by `level_ok`. In that case `irq_pull` is 1 from that edge onward.
- R4: A change sampled with `csn` = 1 leaves `irq_pull` at 1 until an edge where `csn` is sampled 0. `irq_pull` is 0 after that edge if no new change is sampled at it.
- R5: A change sampled with `csn` = 0 starts a pulse. `irq_pull` stays 1 until the edge at which the fifth `tick_us` is sampled, counting only edges after the change, and is 0 after it. With a 1 µs tick this gives a pulse of 4 µs to 5 µs.
- R6: A change sampled during a pulse with `csn` = 0 restarts the tick count from zero and keeps `irq_pull` at 1.
- R7: A change sampled at the same edge at which a pending interrupt would clear takes priority. The interrupt stays asserted and becomes a pulse.
- R8: While `enable` is 0, `data_oe` is 0 whatever `csn` is. At each edge the held code is cleared to 0000 and `irq_pull` is 0 after it.
- R9: After `enable` returns to 1, a nonzero effective code counts as a change from 0000 and raises the interrupt.
- R10: A change sampled during a pulse with `csn` = 1 turns the pulse into a pending interrupt. That interrupt is not removed by later ticks.
- R11: While `rst_n` is 0, `irq_pull` is 0 and the held code is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable; low selects powersave and clears the block |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| class_code | input | 4 | Qualified tone-class code from the classifier |
| level_ok | input | 1 | Signal level is above the detection threshold |
| csn | input | 1 | Host chip select, active low |
| data_out | output | 4 | Held class code, gated by the drive enable |
| data_oe | output | 1 | Drive enable for the data word pads |
| irq_pull | output | 1 | Pull-down enable for the shared interrupt line |

## Verification
Two functions can meet at one clock edge, and these are where the block is most likely to go wrong.

The first case is a new code change arriving in the cycle where chip select falls, just as a pending interrupt would clear. The bench drives a change with chip select high, then pulls chip select low in the very cycle it presents a second code. It expects the line to stay asserted and then run a full five-tick pulse.

The second case is a change that coincides with a tick inside a running pulse. The bench places a tick on the change cycle and counts the ticks after it. It requires exactly five more ticks before release.

Both cases also arise many times in a long pseudo-random sweep, which is judged cycle by cycle against an arithmetic model.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

    typedef enum logic [1:0] {
        IRQ_IDLE  = 2'd0,
        IRQ_HOLD  = 2'd1,
        IRQ_PULSE = 2'd2
    } irq_state_e;

endpackage

// File: rtl/tsp_code_track.sv
module tsp_code_track #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CODE_W-1:0] class_code,
    input  logic              level_ok,
    output logic [CODE_W-1:0] held_code,
    output logic              code_change
);

    logic [CODE_W-1:0] eff_code;

    // Level gate: a weak signal reads as the no-signal code
    always_comb begin
        eff_code = level_ok ? class_code : '0;
    end

    always_comb begin
        code_change = enable && (eff_code != held_code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_code <= '0;
        end else if (!enable) begin
            held_code <= '0;
        end else begin
            held_code <= eff_code;
        end
    end

endmodule

// File: rtl/tsp_pulse_timer.sv
module tsp_pulse_timer #(
    parameter int PULSE_TICKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic expire
);

    localparam int CW = $clog2(PULSE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSE_TICKS - 1);

    logic [CW-1:0] tick_cnt;

    always_comb begin
        expire = run && tick && !restart && (tick_cnt == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (restart || !run) begin
            tick_cnt <= '0;
        end else if (tick) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tsp_irq_fsm.sv
module tsp_irq_fsm
    import tsp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic code_change,
    input  logic csn,
    input  logic expire,
    output logic irq_active,
    output logic pulse_run
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = IRQ_IDLE;                         // powersave
        end else if (code_change) begin
            state_d = csn ? IRQ_HOLD : IRQ_PULSE;       // change_deselected / change_selected
        end else begin
            unique case (state_q)
                IRQ_IDLE:  state_d = IRQ_IDLE;
                IRQ_HOLD:  state_d = csn ? IRQ_HOLD : IRQ_IDLE;      // host_ack
                IRQ_PULSE: state_d = expire ? IRQ_IDLE : IRQ_PULSE;  // pulse_expire
                default:   state_d = IRQ_IDLE;
            endcase
        end
    end

    always_comb begin
        irq_active = 1'b0;
        pulse_run  = 1'b0;
        unique case (state_q)
            IRQ_IDLE:  irq_active = 1'b0;
            IRQ_HOLD:  irq_active = 1'b1;
            IRQ_PULSE: begin
                irq_active = 1'b1;
                pulse_run  = 1'b1;
            end
            default:   irq_active = 1'b0;
        endcase
    end

endmodule

// File: rtl/tone_status_port.sv
module tone_status_port #(
    parameter int CODE_W      = 4,
    parameter int PULSE_TICKS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick_us,
    input  logic [CODE_W-1:0] class_code,
    input  logic              level_ok,
    input  logic              csn,
    output logic [CODE_W-1:0] data_out,
    output logic              data_oe,
    output logic              irq_pull
);

    logic [CODE_W-1:0] held_code;
    logic              code_change;
    logic              pulse_run;
    logic              expire;

    tsp_code_track #(.CODE_W(CODE_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .class_code  (class_code),
        .level_ok    (level_ok),
        .held_code   (held_code),
        .code_change (code_change)
    );

    tsp_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (pulse_run),
        .restart (code_change),
        .tick    (tick_us),
        .expire  (expire)
    );

    tsp_irq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .code_change (code_change),
        .csn         (csn),
        .expire      (expire),
        .irq_active  (irq_pull),
        .pulse_run   (pulse_run)
    );

    assign data_oe = enable & ~csn;

    for (genvar b = 0; b < CODE_W; b++) begin : g_bus
        assign data_out[b] = held_code[b] & data_oe;
    end

endmodule

// File: rtl/tsp_checker.sv
module tsp_checker #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              tick_us,
    input logic              level_ok,
    input logic              csn,
    input logic [CODE_W-1:0] data_out,
    input logic              data_oe,
    input logic              irq_pull
);

    p_bus_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        csn |-> !data_oe);

    p_level_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !level_ok) |=> (!data_oe || data_out == '0));

    p_change_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && $past(data_oe) && data_out != $past(data_out)) |-> irq_pull);

    p_release_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_pull) |-> $past(!csn || tick_us || !enable));

    p_powersave_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !irq_pull);

endmodule

bind tone_status_port tsp_checker #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .tick_us  (tick_us),
    .level_ok (level_ok),
    .csn      (csn),
    .data_out (data_out),
    .data_oe  (data_oe),
    .irq_pull (irq_pull)
);

// File: tb/sim_tone_status_port.sv
`timescale 1ns/1ps
module sim_tone_status_port;

    localparam int PT = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       tick_us = 1'b0;
    logic [3:0] class_code = 4'h0;
    logic       level_ok = 1'b0;
    logic       csn = 1'b1;
    logic [3:0] data_out;
    logic       data_oe;
    logic       irq_pull;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // arithmetic model state
    logic [3:0] m_held = 4'h0;
    int         m_mode = 0;   // 0 idle, 1 pending, 2 pulse
    int         m_rem  = 0;

    always #2 clk = ~clk;

    tone_status_port #(.CODE_W(4), .PULSE_TICKS(PT)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .tick_us    (tick_us),
        .class_code (class_code),
        .level_ok   (level_ok),
        .csn        (csn),
        .data_out   (data_out),
        .data_oe    (data_oe),
        .irq_pull   (irq_pull)
    );

    task automatic model_step();
        logic [3:0] eff;
        if (!enable) begin
            m_held = 4'h0; m_mode = 0; m_rem = 0;
        end else begin
            eff = level_ok ? class_code : 4'h0;
            if (eff != m_held) begin
                m_held = eff;
                if (csn) m_mode = 1;
                else begin m_mode = 2; m_rem = PT; end
            end else if (m_mode == 1 && !csn) begin
                m_mode = 0;
            end else if (m_mode == 2 && tick_us) begin
                m_rem = m_rem - 1;
                if (m_rem == 0) m_mode = 0;
            end
        end
    endtask

    task automatic compare(input string tag);
        logic       e_oe;
        logic [3:0] e_data;
        logic       e_irq;
        e_oe   = enable && !csn;
        e_data = e_oe ? m_held : 4'h0;
        e_irq  = (m_mode != 0);
        checks++;
        if (data_oe !== e_oe || data_out !== e_data || irq_pull !== e_irq) begin
            errors++;
            $display("FAIL %s: oe=%b data=%h irq=%b, expected oe=%b data=%h irq=%b",
                     tag, data_oe, data_out, irq_pull, e_oe, e_data, e_irq);
        end
    endtask

    task automatic drive(input logic en, input logic [3:0] code, input logic lvl,
                         input logic cs, input logic tk, input string tag);
        enable = en; class_code = code; level_ok = lvl; csn = cs; tick_us = tk;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #700000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int tick_seen;
        logic [15:0] lfsr;
        logic [3:0]  sw_code;
        logic        sw_cs;

        // R11: reset state
        repeat (3) @(negedge clk);
        compare("R11");
        checks++;
        if (irq_pull !== 1'b0) begin
            errors++;
            $display("FAIL R11: irq=%b expected 0", irq_pull);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1: drive enable follows chip select and enable with no delay
        for (int i = 0; i < 4; i++) drive(i[1], 4'h0, 1'b1, i[0], 1'b0, "R1");
        drive(1'b1, 4'h0, 1'b1, 1'b1, 1'b0, "R1");

        // R2 / R3: level gate, changes into and out of 0000 while deselected
        drive(1'b1, 4'h5, 1'b0, 1'b1, 1'b0, "R2");
        drive(1'b1, 4'h5, 1'b1, 1'b1, 1'b0, "R3");
        drive(1'b1, 4'h5, 1'b1, 1'b1, 1'b0, "R4");
        drive(1'b1, 4'h5, 1'b0, 1'b1, 1'b0, "R3");
        // R4: pending clears when chip select seen low
        drive(1'b1, 4'h5, 1'b0, 1'b1, 1'b1, "R4");
        drive(1'b1, 4'h5, 1'b0, 1'b0, 1'b0, "R4");
        drive(1'b1, 4'h5, 1'b0, 1'b0, 1'b0, "R2");

        // R5: pulse spans exactly five ticks after the change
        tick_seen = 0;
        drive(1'b1, 4'h3, 1'b1, 1'b0, 1'b1, "R5");
        for (int i = 0; i < 30; i++) begin
            logic tk;
            tk = (i % 3 == 2);
            if (irq_pull && tk) tick_seen++;
            drive(1'b1, 4'h3, 1'b1, 1'b0, tk, "R5");
        end
        checks++;
        if (tick_seen != PT) begin
            errors++;
            $display("FAIL R5: ticks during pulse=%0d expected %0d", tick_seen, PT);
        end

        // R6: restart part way through a pulse
        drive(1'b1, 4'h4, 1'b1, 1'b0, 1'b0, "R6");
        for (int i = 0; i < 9; i++) drive(1'b1, 4'h4, 1'b1, 1'b0, (i % 3 == 0), "R6");
        drive(1'b1, 4'h6, 1'b1, 1'b0, 1'b1, "R6");
        for (int i = 0; i < 20; i++) drive(1'b1, 4'h6, 1'b1, 1'b0, (i % 3 == 0), "R6");

        // R7: change coincides with the acknowledging chip select fall
        drive(1'b1, 4'h7, 1'b1, 1'b1, 1'b0, "R7");
        drive(1'b1, 4'h2, 1'b1, 1'b0, 1'b0, "R7");
        for (int i = 0; i < 20; i++) drive(1'b1, 4'h2, 1'b1, 1'b0, (i % 2 == 0), "R7");

        // R10: change during a pulse with chip select high becomes pending
        drive(1'b1, 4'h9, 1'b1, 1'b0, 1'b0, "R10");
        drive(1'b1, 4'hA, 1'b1, 1'b1, 1'b1, "R10");
        for (int i = 0; i < 12; i++) drive(1'b1, 4'hA, 1'b1, 1'b1, 1'b1, "R10");
        drive(1'b1, 4'hA, 1'b1, 1'b0, 1'b0, "R10");

        // R8: powersave clears everything regardless of chip select
        drive(1'b1, 4'hC, 1'b1, 1'b1, 1'b0, "R8");
        drive(1'b0, 4'hC, 1'b1, 1'b0, 1'b0, "R8");
        drive(1'b0, 4'hC, 1'b1, 1'b1, 1'b0, "R8");
        // R9: re-enable with a nonzero code raises an interrupt
        drive(1'b1, 4'hC, 1'b1, 1'b0, 1'b0, "R9");
        for (int i = 0; i < 16; i++) drive(1'b1, 4'hC, 1'b1, 1'b0, 1'b1, "R9");

        // R3 sweep: pseudo-random codes, level, chip select and enable
        lfsr = 16'hACE1;
        sw_code = 4'h0;
        sw_cs = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[7:5] == 3'd0) sw_code = lfsr[3:0];
            if (i % 400 < 200) sw_cs = 1'b0;
            else if (lfsr[4]) sw_cs = ~sw_cs;
            drive(lfsr[15:11] != 5'd0, sw_code, lfsr[10:8] != 3'd0, sw_cs,
                  (i % 4 == 1), "R3");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule